// File: doc/BRIEF.md
# Dithered High-Resolution Digital PWM

This block drives the high-side switch command of a buck converter from a duty word that has more resolution than its period counter. The duty word is taken in once per switching period, when the period-start strobe is seen. Its upper part sets how many counter steps the pulse lasts. Its lower, fractional part is fed to a first-order sigma-delta accumulator. In the periods where that accumulator carries, the pulse is one counter step longer. Averaged over a bounded number of periods, the duty then resolves to the full width of the command word. This fine average duty lets the regulation loop settle the output inside the converter's zero error bin without limit cycling.

A four-state machine produces the pulse. The states are ST_IDLE, ST_HIGH, ST_FULL and ST_LOW.
- ST_IDLE is the state after reset, before any strobe.
- A strobe moves the machine from any state into one of three states:
  - ST_LOW if the threshold is zero;
  - ST_FULL if the command is all ones;
  - ST_HIGH otherwise.
- ST_HIGH moves to ST_LOW once the counted steps reach the threshold.
- ST_FULL and ST_LOW hold until the next strobe.

A flag output marks the first cycle of each period.

Top module: `dpwm_dither_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pwm_out` and `period_flag` are 0. The dither accumulator starts at 0.
- R2: `period_flag` is 1 for exactly the one cycle after each clock edge that samples `period_start` high, and 0 otherwise.
- R3: The command is split into two fields. Bits [11:4] are the integer part N, and bits [3:0] are the fraction F. At each strobe, A+F is formed from the 4-bit accumulator A. A takes the low 4 bits of that sum. The pulse in that period lasts N+c cycles, where c is the carry out of bit 3.
- R4: A command of zero keeps `pwm_out` low for the whole period.
- R5: The command 12'hFFF keeps `pwm_out` high for the whole period, until the next strobe.
- R6: The command is sampled only on a strobe edge. Changing it during a period does not alter that period's pulse.
- R7: For a constant fraction F, any 16 consecutive periods together hold 16*N+F high cycles. The carry pattern repeats with a period of at most 16.
- R8: Between reset and the first strobe, `pwm_out` stays low.
- R9: The pulse is a single run that starts in the first cycle of the period, the same cycle as `period_flag`. It is followed by low until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | One-cycle strobe that begins a switching period |
| duty_cmd | input | 12 | Duty command: bits [11:4] integer steps, bits [3:0] fraction |
| pwm_out | output | 1 | Switch command |
| period_flag | output | 1 | High in the first cycle of each period |

## Verification
The assertions take for granted that `period_start` is a single-cycle pulse. No two strobes are adjacent, and a period is at least as long as the largest threshold (256 cycles) whenever a full-length pulse is to be seen. The stimulus meets this by raising the strobe for one cycle exactly every 256 cycles. It changes `duty_cmd` only at the strobe, except in the scenario that deliberately alters it in mid-period. The per-period high counts are compared with an accumulator model kept in the bench.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_FULL = 2'd2,
        ST_LOW  = 2'd3
    } pwm_state_t;
endpackage

// File: rtl/dpwm_sd_accum.sv
// First-order sigma-delta stage on the fractional duty bits.
module dpwm_sd_accum #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        carry = sum[FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (load)
            acc_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/dpwm_edge_fsm.sv
// Period state machine: pulse length counter and output decode.
module dpwm_edge_fsm
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int THR_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [THR_W-1:0] thr_i,
    input  logic             full_i,
    output logic             pwm_o,
    output logic             flag_o
);
    pwm_state_t       state_q, state_nx;
    logic [THR_W-1:0] cnt_q, thr_q, cnt_inc;
    logic             flag_q;

    assign cnt_inc = cnt_q + 1'b1;

    // next-state decision
    always_comb begin
        state_nx = state_q;
        if (start) begin
            if (full_i)
                state_nx = ST_FULL;
            else if (thr_i == '0)
                state_nx = ST_LOW;
            else
                state_nx = ST_HIGH;
        end else begin
            unique case (state_q)
                ST_IDLE: state_nx = ST_IDLE;
                ST_HIGH: state_nx = (cnt_inc >= thr_q) ? ST_LOW : ST_HIGH;
                ST_FULL: state_nx = ST_FULL;
                ST_LOW:  state_nx = ST_LOW;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register with counter and threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            thr_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            flag_q  <= start;
            if (start) begin
                cnt_q <= '0;
                thr_q <= thr_i;
            end else if (state_q == ST_HIGH) begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_HIGH, ST_FULL: pwm_o = 1'b1;
            ST_IDLE, ST_LOW:  pwm_o = 1'b0;
            default:          pwm_o = 1'b0;
        endcase
        flag_o = flag_q;
    end
endmodule

// File: rtl/dpwm_dither_top.sv
module dpwm_dither_top #(
    parameter int CNT_W  = 8,
    parameter int FRAC_W = 4,
    localparam int DUTY_W = CNT_W + FRAC_W,
    localparam int THR_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic [DUTY_W-1:0] duty_cmd,
    output logic              pwm_out,
    output logic              period_flag
);
    logic             carry;
    logic             full_scale;
    logic [THR_W-1:0] thr;

    assign full_scale = &duty_cmd;
    assign thr = {1'b0, duty_cmd[DUTY_W-1:FRAC_W]} + {{CNT_W{1'b0}}, carry};

    dpwm_sd_accum #(.FRAC_W(FRAC_W)) accum_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (period_start),
        .frac  (duty_cmd[FRAC_W-1:0]),
        .carry (carry)
    );

    dpwm_edge_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (period_start),
        .thr_i  (thr),
        .full_i (full_scale),
        .pwm_o  (pwm_out),
        .flag_o (period_flag)
    );
endmodule

// File: rtl/dpwm_dither_chk.sv
module dpwm_dither_chk #(
    parameter int DUTY_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              period_start,
    input logic [DUTY_W-1:0] duty_cmd,
    input logic              pwm_out,
    input logic              period_flag
);
    logic seen_q, full_q, zero_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            full_q <= 1'b0;
            zero_q <= 1'b0;
        end else if (period_start) begin
            seen_q <= 1'b1;
            full_q <= &duty_cmd;
            zero_q <= (duty_cmd == '0);
        end
    end

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> period_flag);
    assert_flag_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> !period_flag);
    assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |-> !pwm_out);
    assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> pwm_out);
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !pwm_out);
    assert_rise_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> period_flag);
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_out && !period_start) |=> !pwm_out);
endmodule

bind dpwm_dither_top dpwm_dither_chk #(.DUTY_W(DUTY_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .duty_cmd     (duty_cmd),
    .pwm_out      (pwm_out),
    .period_flag  (period_flag)
);

// File: tb/dpwm_dither_top_tb_top.sv
`timescale 1ns/1ps
module dpwm_dither_top_tb_top;
    localparam int PER = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        period_start = 1'b0;
    logic [11:0] duty_cmd = '0;
    logic        pwm_out, period_flag;

    int   n_checks = 0;
    int   n_fail = 0;
    logic [3:0] acc_m = '0;
    int   last_high = 0;

    always #10 clk = ~clk;

    dpwm_dither_top dut_i (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .duty_cmd(duty_cmd), .pwm_out(pwm_out), .period_flag(period_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; runs one 256-cycle period with duty d.
    // If mid_en, duty_cmd switches to mid_d after 10 cycles.
    task automatic run_period(input logic [11:0] d, input bit mid_en,
                              input logic [11:0] mid_d, input string req);
        logic [4:0] sum;
        int exp_hi, hi, shape_bad;
        sum = {1'b0, acc_m} + {1'b0, d[3:0]};
        acc_m = sum[3:0];
        exp_hi = (d == 12'hFFF) ? PER : int'(d[11:4]) + int'(sum[4]);
        hi = 0;
        shape_bad = 0;
        period_start = 1'b1;
        duty_cmd = d;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (i == 0) begin
                period_start = 1'b0;
                check("R2 flag first cycle", period_flag, 1);
            end
            if (i == 1) check("R2 flag second cycle", period_flag, 0);
            if (mid_en && i == 10) duty_cmd = mid_d;
            if (pwm_out) hi++;
            if (pwm_out != (i < exp_hi)) shape_bad++;
        end
        last_high = hi;
        check({req, " high count (R3)"}, hi, exp_hi);
        check("R9 single pulse from period start, mismatching cycles", shape_bad, 0);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check("R1 pwm in reset", pwm_out, 0);
        check("R1 flag in reset", period_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pwm after reset", pwm_out, 0);
        check("R1 flag after reset", period_flag, 0);
    endtask

    task automatic test_idle();
        int hi = 0;
        duty_cmd = 12'h800;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check("R8 idle high cycles before first strobe", hi, 0);
    endtask

    task automatic test_patterns();
        // accumulator starts at 0 (R1): F=8 gives no carry, then a carry
        run_period(12'h108, 0, '0, "R1 first period F=8");
        check("R1 first period no carry", last_high, 16);
        run_period(12'h108, 0, '0, "R3 second period F=8");
        check("R3 carry on second period", last_high, 17);
        run_period(12'h400, 0, '0, "R3 integer only");
        run_period(12'h7F3, 0, '0, "R3 mixed");
        run_period(12'h013, 0, '0, "R3 small");
        run_period(12'hFF9, 0, '0, "R3 near full");
    endtask

    task automatic test_zero();
        run_period(12'h000, 0, '0, "R4 zero");
        check("R4 zero duty stays low", last_high, 0);
        run_period(12'h000, 0, '0, "R4 zero again");
    endtask

    task automatic test_full();
        run_period(12'hFFF, 0, '0, "R5 full");
        check("R5 full duty stays high", last_high, PER);
        run_period(12'hFFF, 0, '0, "R5 full again");
    endtask

    task automatic test_mid_change();
        run_period(12'h200, 1, 12'hFFF, "R6 change to full mid-period");
        check("R6 pulse unchanged by mid-period command", last_high, 32);
        run_period(12'hA00, 1, 12'h000, "R6 change to zero mid-period");
        check("R6 pulse unchanged by mid-period command", last_high, 160);
    endtask

    task automatic test_dither();
        int tot_a = 0, tot_b = 0;
        for (int k = 0; k < 16; k++) begin
            run_period(12'h5A7, 0, '0, "R7 window A");
            tot_a += last_high;
        end
        for (int k = 0; k < 16; k++) begin
            run_period(12'h5A7, 0, '0, "R7 window B");
            tot_b += last_high;
        end
        check("R7 16-period total window A", tot_a, 16 * 'h5A + 7);
        check("R7 16-period total window B", tot_b, 16 * 'h5A + 7);
    endtask

    initial begin
        #(20.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_idle();
        test_patterns();
        test_zero();
        test_full();
        test_mid_change();
        test_dither();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule